// File: doc/BRIEF.md
# Interrupt Redirection Register File

This block is the software-facing register store of an I/O interrupt controller. A 32-bit bus port offers two byte offsets. Offset 0x00 holds an 8-bit select register. Offset 0x10 is a data window. Every reachable register sits behind the window and is chosen by the select value: a controller identifier, a read-only version word, and one 64-bit redirection entry per interrupt pin. Each entry takes two select codes, one for each 32-bit half.

The whole table is driven out in parallel from registers, so the dispatch logic can inspect every pin's entry (vector, mode and mask bits) without using the bus. Reads come back one cycle after the request together with a valid strobe. Writes land on the clock edge where they are presented.

Top module: `irq_route_regfile`

## Requirements
- R1: A write at byte offset 0x00 stores `bus_wdata[7:0]` as the select value. A read at offset 0x00 returns that value in bits 7:0, with bits 31:8 zero.
- R2: Offset 0x10 reads and writes the register named by the current select value. A write at any other offset changes nothing, and a read there returns zero.
- R3: With select 0x00, a window write stores `bus_wdata[31:24]` as the 8-bit identifier. A window read returns the identifier in bits 31:24, with bits 23:0 zero.
- R4: With select 0x01, a window read returns 0x11 in bits 7:0, NUM_PINS-1 in bits 23:16, and zero in all other bits. Window writes to this code have no effect.
- R5: For a select code s >= 0x10, the entry index is (s-0x10)>>1. An odd s reaches bits 63:32 of that entry and an even s reaches bits 31:0. Entry i appears on `entries_o[64*i+63:64*i]`.
- R6: A write to one half of an entry leaves the other half of that entry unchanged. It also leaves every other entry unchanged.
- R7: Select codes 0x02 to 0x0F, and codes whose entry index is NUM_PINS or more, are ignored on write and read back as zero.
- R8: After synchronous reset, every entry equals 0x0000_0000_0001_0000 (only the mask bit 16 set), and the select and identifier registers are zero.
- R9: `bus_rvalid` is high exactly in the cycle after a read request, and `bus_rdata` is valid in that cycle. A write is visible to a read issued in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the request |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| entries_o | output | 64*NUM_PINS | All redirection entries, entry i at bits 64i+63:64i |

## Verification
All 256 select codes are swept twice: once right after reset and once after every entry half has been loaded with a pattern derived from its own select code. The reset sweep separates mask-only entries from the identifier, version and unused codes. In the loaded sweep each half carries a distinct value, so an index-mapping error or a half swap would show up.

After every entry write, the entry's parallel output is compared against a model. This catches a write that disturbs the opposite half. Writes to unused codes, to the version code and to foreign offsets are followed by a full table comparison and a select readback. Back-to-back write-then-read pairs show when writes become visible and that read data arrives one cycle after the request.

// File: rtl/irq_rf_pkg.sv
package irq_rf_pkg;
  // What the current select value points at
  typedef enum logic [1:0] {
    TGT_ID    = 2'd0,
    TGT_VER   = 2'd1,
    TGT_ENTRY = 2'd2,
    TGT_NONE  = 2'd3
  } tgt_e;

  localparam int          ENTRY_W     = 64;
  localparam int          WORD_W      = 32;
  localparam int          SEL_W       = 8;
  localparam int          MASK_BIT    = 16;
  localparam logic [7:0]  VERSION_LO  = 8'h11;
  localparam logic [7:0]  ENTRY_BASE  = 8'h10;
  localparam logic [63:0] ENTRY_RESET = 64'(1) << MASK_BIT;
endpackage

// File: rtl/irq_rf_sel_decode.sv
module irq_rf_sel_decode
  import irq_rf_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic [SEL_W-1:0] sel,
  output tgt_e             tgt,
  output logic [IDX_W-1:0] idx,
  output logic             upper
);
  localparam int PAIR_W = SEL_W - 1;

  logic [PAIR_W-1:0] pair;
  logic              above_base;
  logic              in_range;

  always_comb begin
    above_base = (sel >= ENTRY_BASE);
    pair       = sel[SEL_W-1:1] - ENTRY_BASE[SEL_W-1:1];
    in_range   = above_base && (int'(pair) < NUM_PINS);
    upper      = sel[0];
    idx        = in_range ? pair[IDX_W-1:0] : '0;
    if (sel == 8'h00)      tgt = TGT_ID;
    else if (sel == 8'h01) tgt = TGT_VER;
    else if (in_range)     tgt = TGT_ENTRY;
    else                   tgt = TGT_NONE;
  end
endmodule

// File: rtl/irq_rf_entry_bank.sv
module irq_rf_entry_bank
  import irq_rf_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic                        wr_upper,
  input  logic [WORD_W-1:0]           wr_data,
  input  logic [IDX_W-1:0]            rd_idx,
  input  logic                        rd_upper,
  output logic [WORD_W-1:0]           rd_data,
  output logic [NUM_PINS*ENTRY_W-1:0] entries_o
);
  logic [ENTRY_W-1:0] ent [NUM_PINS];

  for (genvar e = 0; e < NUM_PINS; e++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (rst) begin
        ent[e] <= ENTRY_RESET;
      end else if (hit) begin
        if (wr_upper) ent[e][ENTRY_W-1:WORD_W] <= wr_data;
        else          ent[e][WORD_W-1:0]       <= wr_data;
      end
    end

    assign entries_o[e*ENTRY_W +: ENTRY_W] = ent[e];
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_idx) < NUM_PINS) begin
      rd_data = rd_upper ? ent[rd_idx][ENTRY_W-1:WORD_W] : ent[rd_idx][WORD_W-1:0];
    end
  end
endmodule

// File: rtl/irq_rf_read_mux.sv
module irq_rf_read_mux
  import irq_rf_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic              is_sel_ofs,
  input  logic              is_win_ofs,
  input  tgt_e              tgt,
  input  logic [SEL_W-1:0]  sel_val,
  input  logic [7:0]        id_val,
  input  logic [WORD_W-1:0] entry_half,
  output logic [WORD_W-1:0] rd_word
);
  localparam logic [7:0] MAX_IDX = 8'(NUM_PINS - 1);
  localparam logic [WORD_W-1:0] VER_WORD = {8'h00, MAX_IDX, 8'h00, VERSION_LO};

  always_comb begin
    rd_word = '0;
    if (is_sel_ofs) begin
      rd_word = {{(WORD_W-SEL_W){1'b0}}, sel_val};
    end else if (is_win_ofs) begin
      unique case (tgt)
        TGT_ID:    rd_word = {id_val, 24'h0};
        TGT_VER:   rd_word = VER_WORD;
        TGT_ENTRY: rd_word = entry_half;
        default:   rd_word = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile
  import irq_rf_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int ADDR_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_valid,
  input  logic                        bus_write,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  output logic                        bus_rvalid,
  output logic [NUM_PINS*64-1:0]      entries_o
);
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam logic [ADDR_W-1:0] OFS_SEL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_WIN = ADDR_W'(8'h10);

  logic [SEL_W-1:0]  sel_q;
  logic [7:0]        id_q;
  tgt_e              tgt;
  logic [IDX_W-1:0]  idx;
  logic              upper;
  logic              is_sel_ofs, is_win_ofs;
  logic              wr_req, rd_req;
  logic              entry_wr;
  logic [WORD_W-1:0] entry_half;
  logic [WORD_W-1:0] rd_word;

  assign is_sel_ofs = (bus_addr == OFS_SEL);
  assign is_win_ofs = (bus_addr == OFS_WIN);
  assign wr_req     = bus_valid && bus_write;
  assign rd_req     = bus_valid && !bus_write;
  assign entry_wr   = wr_req && is_win_ofs && (tgt == TGT_ENTRY);

  irq_rf_sel_decode #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_dec (
    .sel   (sel_q),
    .tgt   (tgt),
    .idx   (idx),
    .upper (upper)
  );

  irq_rf_entry_bank #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (entry_wr),
    .wr_idx    (idx),
    .wr_upper  (upper),
    .wr_data   (bus_wdata),
    .rd_idx    (idx),
    .rd_upper  (upper),
    .rd_data   (entry_half),
    .entries_o (entries_o)
  );

  irq_rf_read_mux #(.NUM_PINS(NUM_PINS)) u_rmux (
    .is_sel_ofs (is_sel_ofs),
    .is_win_ofs (is_win_ofs),
    .tgt        (tgt),
    .sel_val    (sel_q),
    .id_val     (id_q),
    .entry_half (entry_half),
    .rd_word    (rd_word)
  );

  // Select and identifier registers
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      id_q  <= '0;
    end else if (wr_req) begin
      if (is_sel_ofs) sel_q <= bus_wdata[SEL_W-1:0];
      if (is_win_ofs && tgt == TGT_ID) id_q <= bus_wdata[31:24];
    end
  end

  // Registered read return
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req) bus_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/irq_route_regfile_chk.sv
module irq_route_regfile_chk #(
  parameter int NUM_PINS = 24,
  parameter int ADDR_W   = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   bus_valid,
  input logic                   bus_write,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [31:0]            bus_rdata,
  input logic                   bus_rvalid,
  input logic [7:0]             sel_q,
  input logic [NUM_PINS*64-1:0] entries_o
);
  localparam logic [31:0] EXP_VER = {8'h00, 8'(NUM_PINS - 1), 8'h00, 8'h11};
  logic rd, win;
  assign rd  = bus_valid && !bus_write;
  assign win = (bus_addr == ADDR_W'(8'h10));

  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (rst)
    rd |=> bus_rvalid); // R9
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (rst)
    !rd |=> !bus_rvalid); // R9
  AST_TABLE_HOLDS_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && bus_write) |=> $stable(entries_o)); // R6
  AST_SELECT_READBACK: assert property (@(posedge clk) disable iff (rst)
    (rd && bus_addr == ADDR_W'(8'h00)) |=> bus_rdata == {24'h0, $past(sel_q)}); // R1
  AST_VERSION_WORD: assert property (@(posedge clk) disable iff (rst)
    (rd && win && sel_q == 8'h01) |=> bus_rdata == EXP_VER); // R4
  AST_ID_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd && win && sel_q == 8'h00) |=> bus_rdata[23:0] == 24'h0); // R3
endmodule

bind irq_route_regfile irq_route_regfile_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .sel_q      (sel_q),
  .entries_o  (entries_o)
);

// File: tb/tb_irq_route_regfile.sv
`timescale 1ns/1ps
module tb_irq_route_regfile;
  localparam int N      = 24;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_valid = 1'b0;
  logic              bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr  = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              bus_rvalid;
  logic [N*64-1:0]   entries_o;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  logic [63:0] m_ent [N];
  logic [7:0]  m_id;

  always #4 clk = ~clk;

  irq_route_regfile #(.NUM_PINS(N), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .entries_o(entries_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Tasks are entered at a negative edge and return at one
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic v);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata; v = bus_rvalid;
    bus_valid = 1'b0;
  endtask

  function automatic logic [31:0] exp_win(input int s);
    int ix;
    if (s == 0) return {m_id, 24'h0};
    if (s == 1) return {8'h00, 8'(N - 1), 8'h00, 8'h11};
    if (s < 16) return 32'h0;
    ix = (s - 16) >> 1;
    if (ix >= N) return 32'h0;
    return (s % 2 == 1) ? m_ent[ix][63:32] : m_ent[ix][31:0];
  endfunction

  function automatic logic [31:0] pat(input int s);
    logic [7:0] b;
    b = 8'(s);
    return {b, ~b, 8'h3C, b ^ 8'h96};
  endfunction

  task automatic check_table(input string req);
    for (int i = 0; i < N; i++) chk(req, entries_o[i*64 +: 64], m_ent[i]);
  endtask

  task automatic sweep(input string req);
    logic [31:0] d;
    logic v;
    for (int s = 0; s < 256; s++) begin
      wr(8'h00, 32'(s));
      rd(8'h00, d, v);
      chk("R1 select readback", {v, d}, {1'b1, 24'h0, 8'(s)});
      rd(8'h10, d, v);
      chk(req, {v, d}, {1'b1, exp_win(s)});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic v;
    for (int i = 0; i < N; i++) m_ent[i] = 64'h0000_0000_0001_0000;
    m_id = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R8: reset state
    chk("R9 rvalid idle after reset", bus_rvalid, 1'b0);
    check_table("R8 entry reset value");
    rd(8'h00, d, v);
    chk("R8 select reset", {v, d}, {1'b1, 32'h0});
    rd(8'h10, d, v);
    chk("R8 id reset", {v, d}, {1'b1, 32'h0});

    // Reset sweep over all select codes (R2, R4, R5, R7)
    sweep("R7 R5 window read after reset");

    // R3: identifier
    wr(8'h00, 32'h0);
    wr(8'h10, 32'hA5FF_FFFF);
    m_id = 8'hA5;
    chk("R9 no rvalid on write", bus_rvalid, 1'b0);
    rd(8'h10, d, v);
    chk("R3 id stored from top byte", {v, d}, {1'b1, 32'hA500_0000});

    // R4: version write ignored
    wr(8'h00, 32'h1);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, d, v);
    chk("R4 version read-only", d, {8'h00, 8'(N - 1), 8'h00, 8'h11});
    check_table("R4 version write leaves table");

    // R6/R5: load every entry half, checking the opposite half each time
    for (int s = 16; s < 256; s++) begin
      int ix;
      wr(8'h00, 32'(s));
      wr(8'h10, pat(s));
      ix = (s - 16) >> 1;
      if (ix < N) begin
        if (s % 2 == 1) m_ent[ix][63:32] = pat(s);
        else            m_ent[ix][31:0]  = pat(s);
        chk("R6 half write keeps other half", entries_o[ix*64 +: 64], m_ent[ix]);
        // R9: write visible to the read in the next cycle
        rd(8'h10, d, v);
        chk("R9 write then immediate read", {v, d}, {1'b1, pat(s)});
      end
    end
    check_table("R7 R6 table after out-of-range writes");

    // R7: unused low codes ignored
    for (int s = 2; s < 16; s++) begin
      wr(8'h00, 32'(s));
      wr(8'h10, 32'hDEAD_BEEF);
    end
    check_table("R7 unused codes leave table");

    // Loaded sweep (R5)
    sweep("R5 window read after load");

    // R2: other offsets
    wr(8'h00, 32'h12);
    wr(8'h04, 32'h0000_0077);
    wr(8'h20, 32'h5555_5555);
    wr(8'h11, 32'h6666_6666);
    rd(8'h00, d, v);
    chk("R2 foreign offset keeps select", d, 32'h12);
    check_table("R2 foreign offset keeps table");
    rd(8'h08, d, v);
    chk("R2 foreign offset reads zero", {v, d}, {1'b1, 32'h0});
    rd(8'h10, d, v);
    chk("R2 window follows select", d, m_ent[1][31:0]);
    @(negedge clk);
    chk("R9 rvalid drops after read", bus_rvalid, 1'b0);

    // R8: reset again restores the masked state
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < N; i++) m_ent[i] = 64'h0000_0000_0001_0000;
    check_table("R8 entries after second reset");
    rd(8'h00, d, v);
    chk("R8 select cleared", d, 32'h0);
    rd(8'h10, d, v);
    chk("R8 id cleared", d, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule